// File: doc/BRIEF.md
# Enhanced-Mode Unlock Detector

This block watches the byte-wide register bus of a 32-input digital input module and decides when the module leaves its standard operating mode for its enhanced mode. The switch needs a fixed four-byte key, 07h then 0Dh then 06h then 12h. The key must be written to the key register address (parameter `KEY_ADDR`, default 7). The writes must be back to back, with no other bus access between them, and interrupts must be disabled. The key only works in the window that opens at reset. Once any access other than a write to the key address has happened, that window is closed until the next reset.

After the unlock, the block drives a sticky mode flag and a bank index that the register decoder uses to route accesses. In standard mode the bank index is always 0. In enhanced mode, software picks bank 0, 1 or 2 by writing the bank number in data bits [1:0] to the key address. The bus uses single-cycle strobes. An access is any cycle with `wr_en` or `rd_en` high. The block always accepts an access in the cycle it is presented and never applies back-pressure.

Top module: `mode_unlock`

## Requirements
- R1: After reset is released, `enh_mode` is 0 and `bank_idx` is 0.
- R2: Writing 07h, 0Dh, 06h and 12h to `KEY_ADDR` as four consecutive accesses, with `irq_en` low and the window open, sets `enh_mode` on the clock edge that samples the fourth write. Idle cycles between the writes are allowed.
- R3: A read or write to any address other than `KEY_ADDR` aborts an attempt in progress. It also closes the unlock window, so a later complete key does not unlock.
- R4: A read of `KEY_ADDR` counts as an intervening access. It aborts the attempt and closes the window. A cycle with both `wr_en` and `rd_en` high is treated the same way.
- R5: A write of a wrong byte to `KEY_ADDR` sends the matcher back to the first key byte and leaves the window open. If that wrong byte is 07h, it counts as the first key byte.
- R6: While `irq_en` is high, writes to `KEY_ADDR` in standard mode are ignored. They neither advance nor reset the matcher. A key written entirely with `irq_en` high does not unlock.
- R7: `enh_mode` stays 1 until the next reset, whatever the bus does. Reset returns it to 0 and reopens the window.
- R8: In enhanced mode, a write to `KEY_ADDR` with data bits [1:0] equal to 0, 1 or 2 loads `bank_idx` on that clock edge. The value 3 leaves it unchanged. Accesses to other addresses leave it unchanged. `bank_idx` is 0 on the edge where the mode switches.
- R9: In standard mode `bank_idx` stays 0 for any bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (power-up or bus reset) |
| addr | input | ADDR_W | Register address of the current access |
| wdata | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| irq_en | input | 1 | Interrupt enable state; high blocks key writes |
| enh_mode | output | 1 | 1 once enhanced mode is unlocked |
| bank_idx | output | 2 | Bank selected for the register decoder |

## Verification
The hardest situation to reach from the ports is a write that is ignored because `irq_en` is high. The ignored write must land in the middle of a partly matched key. Its effect only shows up later, when the rest of the key either completes the unlock or fails to. The bench reaches it in two steps. It writes the first two key bytes with interrupts off. It then writes a wrong byte with `irq_en` high, drops `irq_en`, and finishes the key. A second case shows that a wrong byte sent with `irq_en` low does reset the match, but the window stays open. A behavioural reference model is checked against the outputs on every cycle of all these sequences.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

  localparam int KEY_LEN = 4;
  localparam int POS_W   = $clog2(KEY_LEN);
  localparam int BANK_W  = 2;
  localparam int NUM_BANKS = 3;

  function automatic logic [7:0] key_byte(input logic [POS_W-1:0] idx);
    case (idx)
      2'd0:    key_byte = 8'h07;
      2'd1:    key_byte = 8'h0D;
      2'd2:    key_byte = 8'h06;
      default: key_byte = 8'h12;
    endcase
  endfunction

  typedef struct packed {
    logic key_wr;    // plain write to the key address
    logic other;     // any access that is not a plain key-address write
  } acc_kind_t;

endpackage

// File: rtl/unlock_access_classify.sv
module unlock_access_classify
  import unlock_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int KEY_ADDR = 7
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output acc_kind_t         kind
);
  localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(KEY_ADDR);

  logic hit;
  assign hit = (addr == KEY_A);

  always_comb begin
    kind.key_wr = wr_en && !rd_en && hit;
    kind.other  = (wr_en || rd_en) && !(wr_en && !rd_en && hit);
  end
endmodule

// File: rtl/unlock_key_matcher.sv
module unlock_key_matcher
  import unlock_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  acc_kind_t kind,
  input  logic [7:0] wdata,
  input  logic      irq_en,
  output logic      unlocked
);
  localparam logic [POS_W-1:0] LAST = POS_W'(KEY_LEN - 1);

  logic             window;
  logic [POS_W-1:0] pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      window   <= 1'b1;
      pos      <= '0;
      unlocked <= 1'b0;
    end else if (!unlocked) begin
      if (kind.other) begin
        window <= 1'b0;
        pos    <= '0;
      end else if (kind.key_wr && !irq_en && window) begin
        if (wdata == key_byte(pos)) begin
          if (pos == LAST) begin
            unlocked <= 1'b1;
            pos      <= '0;
          end else begin
            pos <= pos + 1'b1;
          end
        end else if (wdata == key_byte('0)) begin
          pos <= POS_W'(1);
        end else begin
          pos <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/unlock_bank_reg.sv
module unlock_bank_reg
  import unlock_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enh,
  input  acc_kind_t         kind,
  input  logic [BANK_W-1:0] sel,
  output logic [BANK_W-1:0] bank
);
  logic sel_ok;
  assign sel_ok = (int'(sel) < NUM_BANKS);

  always_ff @(posedge clk) begin
    if (!rst_n)
      bank <= '0;
    else if (enh && kind.key_wr && sel_ok)
      bank <= sel;
  end
endmodule

// File: rtl/mode_unlock.sv
module mode_unlock
  import unlock_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int KEY_ADDR = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              irq_en,
  output logic              enh_mode,
  output logic [1:0]        bank_idx
);
  acc_kind_t kind;

  unlock_access_classify #(.ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR)) u_cls (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .kind(kind)
  );

  unlock_key_matcher u_match (
    .clk(clk), .rst_n(rst_n), .kind(kind), .wdata(wdata),
    .irq_en(irq_en), .unlocked(enh_mode)
  );

  unlock_bank_reg u_bank (
    .clk(clk), .rst_n(rst_n), .enh(enh_mode), .kind(kind),
    .sel(wdata[BANK_W-1:0]), .bank(bank_idx)
  );
endmodule

// File: rtl/mode_unlock_chk.sv
module mode_unlock_chk #(
  parameter int ADDR_W   = 5,
  parameter int KEY_ADDR = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic              wr_en,
  input logic              rd_en,
  input logic              irq_en,
  input logic              enh_mode,
  input logic [1:0]        bank_idx
);
  localparam logic [ADDR_W-1:0] KA = ADDR_W'(KEY_ADDR);

  AST_STD_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_mode |-> bank_idx == 2'd0); // R9
  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    enh_mode |=> enh_mode); // R7
  AST_RISE_ON_LAST_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enh_mode) |-> $past(wr_en && !rd_en && addr == KA && wdata == 8'h12)); // R2
  AST_RISE_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enh_mode) |-> !$past(irq_en)); // R6
  AST_NO_RISE_AFTER_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || (wr_en && addr != KA)) |=> !$rose(enh_mode)); // R3
  AST_BANK_ZERO_AT_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enh_mode) |-> bank_idx == 2'd0); // R8
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_mode && !(wr_en && !rd_en && addr == KA)) |=> $stable(bank_idx)); // R8
  AST_BANK_NEVER_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    bank_idx != 2'd3); // R8
endmodule

bind mode_unlock mode_unlock_chk #(.ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
  .rd_en(rd_en), .irq_en(irq_en), .enh_mode(enh_mode), .bank_idx(bank_idx)
);

// File: tb/mode_unlock_bench.sv
module mode_unlock_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 5;
  localparam int KADDR = 7;

  logic clk = 0;
  logic rst_n = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr_en = 0, rd_en = 0, irq_en = 0;
  logic enh_mode;
  logic [1:0] bank_idx;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mode_unlock #(.ADDR_W(ADDR_W), .KEY_ADDR(KADDR)) u_mode_unlock (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .irq_en(irq_en), .enh_mode(enh_mode), .bank_idx(bank_idx)
  );

  // Behavioural reference model
  byte unsigned key_q[$] = '{8'h07, 8'h0D, 8'h06, 8'h12};
  byte unsigned got_q[$];
  bit m_open = 1;
  bit m_enh = 0;
  int m_bank = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_open = 1; m_enh = 0; m_bank = 0; got_q.delete();
    end else if (m_enh) begin
      if (wr_en && !rd_en && addr == KADDR && wdata[1:0] != 2'd3)
        m_bank = int'(wdata[1:0]);
    end else if (wr_en || rd_en) begin
      if (wr_en && !rd_en && addr == KADDR) begin
        if (!irq_en && m_open) begin
          if (wdata == key_q[got_q.size()]) got_q.push_back(wdata);
          else begin
            got_q.delete();
            if (wdata == key_q[0]) got_q.push_back(wdata);
          end
          if (got_q.size() == key_q.size()) begin
            m_enh = 1; got_q.delete();
          end
        end
      end else begin
        m_open = 0; got_q.delete();
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (enh_mode !== m_enh || int'(bank_idx) != m_bank) begin
        errors++;
        $display("FAIL model R2/R8 mode=%0b bank=%0d expected mode=%0b bank=%0d",
                 enh_mode, bank_idx, m_enh, m_bank);
      end
    end
  end

  task automatic check(input string req, input logic exp_mode, input int exp_bank);
    checks++;
    if (enh_mode !== exp_mode || int'(bank_idx) != exp_bank) begin
      errors++;
      $display("FAIL %s mode=%0b bank=%0d expected mode=%0b bank=%0d",
               req, enh_mode, bank_idx, exp_mode, exp_bank);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; wr_en = 0; rd_en = 0; irq_en = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); addr = ADDR_W'(a); wdata = 8'(d); wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a);
    @(negedge clk); addr = ADDR_W'(a); rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic send_key();
    foreach (key_q[i]) wr(KADDR, key_q[i]);
  endtask

  initial begin
    do_reset();
    check("R1", 0, 0);

    // R2 full key, with an idle cycle inside
    wr(KADDR, 8'h07); wr(KADDR, 8'h0D); @(negedge clk);
    wr(KADDR, 8'h06); check("R2", 0, 0);
    wr(KADDR, 8'h12); check("R2", 1, 0);
    // R8 bank selection
    wr(KADDR, 2); check("R8", 1, 2);
    wr(KADDR, 3); check("R8", 1, 2);
    wr(3, 1); rd(KADDR); check("R8", 1, 2);
    wr(KADDR, 8'h41); check("R8", 1, 1);
    // R7 sticky
    wr(2, 8'h00); rd(5); irq_en = 1; wr(KADDR, 0); irq_en = 0;
    check("R7", 1, 0);
    do_reset(); check("R7", 0, 0);

    // R3 other address read between key bytes, then window closed
    wr(KADDR, 8'h07); wr(KADDR, 8'h0D); rd(2);
    wr(KADDR, 8'h06); wr(KADDR, 8'h12); check("R3", 0, 0);
    send_key(); check("R3", 0, 0);
    do_reset(); wr(4, 8'h07); send_key(); check("R3", 0, 0);

    // R4 read of key address cancels
    do_reset();
    wr(KADDR, 8'h07); wr(KADDR, 8'h0D); rd(KADDR);
    wr(KADDR, 8'h06); wr(KADDR, 8'h12); check("R4", 0, 0);
    send_key(); check("R4", 0, 0);
    do_reset();
    @(negedge clk); addr = ADDR_W'(KADDR); wdata = 8'h07; wr_en = 1; rd_en = 1;
    @(negedge clk); wr_en = 0; rd_en = 0;
    send_key(); check("R4", 0, 0);

    // R5 wrong byte 07h restarts at position two
    do_reset();
    wr(KADDR, 8'h07); wr(KADDR, 8'h0D); wr(KADDR, 8'h07);
    wr(KADDR, 8'h0D); wr(KADDR, 8'h06); wr(KADDR, 8'h12); check("R5", 1, 0);
    // R5 other wrong byte resets matcher, window stays open
    do_reset();
    wr(KADDR, 8'h07); wr(KADDR, 8'h0D); wr(KADDR, 8'h55);
    wr(KADDR, 8'h06); wr(KADDR, 8'h12); check("R5", 0, 0);
    send_key(); check("R5", 1, 0);

    // R6 ignored write under irq_en keeps partial match
    do_reset();
    wr(KADDR, 8'h07); wr(KADDR, 8'h0D);
    irq_en = 1; wr(KADDR, 8'h55); irq_en = 0;
    wr(KADDR, 8'h06); wr(KADDR, 8'h12); check("R6", 1, 0);
    do_reset();
    irq_en = 1; send_key(); irq_en = 0; check("R6", 0, 0);

    // R9 bank held at zero in standard mode
    do_reset();
    wr(KADDR, 8'h02); wr(KADDR, 8'h01); check("R9", 0, 0);
    wr(1, 8'h02); check("R9", 0, 0);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog R1 expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule